// File: doc/BRIEF.md
# Drop Tally and Interrupt Unit

This block sits beside a camera-stream receiver and keeps score of the packets that the receiver throws away. The receiver raises one strobe per drop category (buffer overflow, length limit, unmatched stream, inactive channel) together with the size of the loss, the packet's data type and its virtual channel. For every category the block holds one 32-bit word that accumulates the lost amount and remembers the data type and virtual channel of the latest drop. A separate strobe reports a receive FIFO overflow, which has no counter and only raises an event.

All events are latched in a sticky status register that software clears by writing ones. A five-bit enable register selects which latched events drive the single interrupt line. A simple register port (write strobe, byte address, write data, combinational read data) gives software access to status, enables and the four counter words. Software harvests a counter by reading it and then writing zero to it.

Top module: `drop_tally_irq`

## Requirements
- R1: After a synchronous active-low reset every counter word, the status register and the enable register read zero and `irq_o` is low.
- R2: The counter words sit at byte addresses 0x08 (overflow drops), 0x0C (inactive-channel drops), 0x10 (unmatched drops) and 0x14 (length-limit drops); each word reads amount in bits 23:0, data type in bits 29:24 and virtual channel in bits 31:30.
- R3: The status register at 0x00 holds sticky event bits: bit 20 for a FIFO overflow strobe, and bits 21, 22, 23, 24 for overflow, length-limit, unmatched and inactive drops; all other bits read zero.
- R4: A write to 0x00 clears each status bit whose write-data bit is one and leaves the rest; an event arriving in the same cycle as its clear leaves the bit set.
- R5: Each drop strobe adds its amount to that category's amount field in the following cycle.
- R6: The amount field saturates at 0xFFFFFF instead of wrapping.
- R7: Every drop strobe loads its data type and virtual channel into the category's word, replacing the previous ones.
- R8: Writing zero to a counter address clears the whole word; a nonzero write to a counter address has no effect.
- R9: A drop strobe and a zero write to the same counter in one cycle leave the word holding exactly the new amount, data type and virtual channel.
- R10: The enable register at 0x20 reads back bits 4:0 as written, bit 0 enabling the FIFO overflow event and bits 1 to 4 the overflow, length-limit, unmatched and inactive drop events; `irq_o` is high whenever a status bit 20+i and enable bit i are both set.
- R11: Reads of addresses outside 0x00, 0x08, 0x0C, 0x10, 0x14 and 0x20 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_ovf_i | input | 1 | Receive FIFO overflow strobe |
| drop_valid_i | input | 4 | Drop strobes: bit 0 overflow, 1 length limit, 2 unmatched, 3 inactive |
| drop_amount_i | input | 96 | Amount per category, category k in bits 24k+23:24k |
| drop_dtype_i | input | 24 | Data type per category, category k in bits 6k+5:6k |
| drop_vchan_i | input | 8 | Virtual channel per category, category k in bits 2k+1:2k |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Interrupt, high while an enabled status bit is set |

## Verification
The bench builds the block with its default widths: a 24-bit amount, a 6-bit data type and a 2-bit virtual channel. With these values every one of the 64 data types and all four virtual channels are driven through each category, all 32 by 32 combinations of status and enable bits are visited, and the saturation point is reached within a few large drops. Same-cycle collisions between clears and events are exercised on both status and counter words.

// File: rtl/drop_tally_pkg.sv
// Shared constants for the drop tally unit.
// Assumes byte addressing on the register port and four drop categories.
package drop_tally_pkg;
    localparam int NCAT    = 4;           // drop categories
    localparam int NSRC    = NCAT + 1;    // status sources incl. FIFO overflow
    localparam int STAT_LSB = 20;         // first status bit position

    localparam logic [7:0] ADDR_STATUS = 8'h00;
    localparam logic [7:0] ADDR_ENABLE = 8'h20;

    // Category index order: 0 overflow, 1 length limit, 2 unmatched, 3 inactive.
    // Index order matches the status and enable bit order.
    function automatic logic [7:0] cat_addr(input int k);
        case (k)
            0:       return 8'h08;
            1:       return 8'h14;
            2:       return 8'h10;
            default: return 8'h0C;
        endcase
    endfunction
endpackage

// File: rtl/drop_counter.sv
// One drop category: saturating amount plus data type and virtual channel
// of the latest drop. Assumes ev_i and clr_i are single-cycle qualified strobes;
// an event coinciding with a clear loads the event on top of zero.
module drop_counter #(
    parameter int AMT_W = 24,
    parameter int DT_W  = 6,
    parameter int VC_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic [DT_W-1:0]  dt_i,
    input  logic [VC_W-1:0]  vc_i,
    input  logic             clr_i,
    output logic [AMT_W-1:0] amt_o,
    output logic [DT_W-1:0]  dt_o,
    output logic [VC_W-1:0]  vc_o
);
    localparam logic [AMT_W-1:0] AMT_MAX = {AMT_W{1'b1}};

    logic [AMT_W-1:0] amt_q;
    logic [DT_W-1:0]  dt_q;
    logic [VC_W-1:0]  vc_q;
    logic [AMT_W-1:0] base;
    logic [AMT_W:0]   sum;
    logic [AMT_W-1:0] amt_next;

    // Saturating add of the incoming amount onto the (possibly cleared) tally.
    always_comb begin
        base     = clr_i ? '0 : amt_q;
        sum      = {1'b0, base} + {1'b0, amt_i};
        amt_next = sum[AMT_W] ? AMT_MAX : sum[AMT_W-1:0];
    end

    // Tally register: event first, then software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            amt_q <= '0;
            dt_q  <= '0;
            vc_q  <= '0;
        end else if (ev_i) begin
            amt_q <= amt_next;
            dt_q  <= dt_i;
            vc_q  <= vc_i;
        end else if (clr_i) begin
            amt_q <= '0;
            dt_q  <= '0;
            vc_q  <= '0;
        end
    end

    assign amt_o = amt_q;
    assign dt_o  = dt_q;
    assign vc_o  = vc_q;
endmodule

// File: rtl/drop_status.sv
// Sticky event register with write-one-to-clear and an enable register
// gating one interrupt line. Assumes set has priority over a same-cycle clear.
module drop_status #(
    parameter int NSRC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic            clr_we_i,
    input  logic [NSRC-1:0] clr_bits_i,
    input  logic            en_we_i,
    input  logic [NSRC-1:0] en_i,
    output logic [NSRC-1:0] stat_o,
    output logic [NSRC-1:0] en_o,
    output logic            irq_o
);
    logic [NSRC-1:0] stat_q;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] clr_mask;

    // Bits software asks to clear this cycle.
    always_comb clr_mask = clr_we_i ? clr_bits_i : '0;

    // Status latch: clear requested bits, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | set_i;
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (en_we_i) en_q <= en_i;
    end

    assign stat_o = stat_q;
    assign en_o   = en_q;
    assign irq_o  = |(stat_q & en_q);
endmodule

// File: rtl/drop_tally_irq.sv
// Top of the drop tally unit: four category counters, the sticky status and
// enable registers, address decode and the combinational read mux.
// Assumes AMT_W + DT_W + VC_W equals DATA_W so a counter fits one word.
module drop_tally_irq
    import drop_tally_pkg::*;
#(
    parameter int AMT_W  = 24,
    parameter int DT_W   = 6,
    parameter int VC_W   = 2,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fifo_ovf_i,
    input  logic [NCAT-1:0]       drop_valid_i,
    input  logic [NCAT*AMT_W-1:0] drop_amount_i,
    input  logic [NCAT*DT_W-1:0]  drop_dtype_i,
    input  logic [NCAT*VC_W-1:0]  drop_vchan_i,
    input  logic                  reg_we_i,
    input  logic [ADDR_W-1:0]     reg_addr_i,
    input  logic [DATA_W-1:0]     reg_wdata_i,
    output logic [DATA_W-1:0]     reg_rdata_o,
    output logic                  irq_o
);
    localparam int DT_LSB = AMT_W;
    localparam int VC_LSB = AMT_W + DT_W;

    logic [DATA_W-1:0]     cnt_word [NCAT];
    logic [NCAT*AMT_W-1:0] amt_all;
    logic [NSRC-1:0]       stat_w;
    logic [NSRC-1:0]       en_w;
    logic                  hit_status;
    logic                  hit_enable;

    // Decode of the two control addresses.
    always_comb begin
        hit_status = (reg_addr_i == ADDR_W'(ADDR_STATUS));
        hit_enable = (reg_addr_i == ADDR_W'(ADDR_ENABLE));
    end

    for (genvar g = 0; g < NCAT; g++) begin : g_cat
        logic             clr;
        logic [AMT_W-1:0] amt;
        logic [DT_W-1:0]  dt;
        logic [VC_W-1:0]  vc;

        // A zero write to this counter's address clears it.
        always_comb clr = reg_we_i && (reg_addr_i == ADDR_W'(cat_addr(g)))
                          && (reg_wdata_i == '0);

        drop_counter #(.AMT_W(AMT_W), .DT_W(DT_W), .VC_W(VC_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .ev_i  (drop_valid_i[g]),
            .amt_i (drop_amount_i[g*AMT_W +: AMT_W]),
            .dt_i  (drop_dtype_i[g*DT_W +: DT_W]),
            .vc_i  (drop_vchan_i[g*VC_W +: VC_W]),
            .clr_i (clr),
            .amt_o (amt),
            .dt_o  (dt),
            .vc_o  (vc)
        );

        // Pack the counter into its register word.
        always_comb begin
            cnt_word[g] = '0;
            cnt_word[g][AMT_W-1:0]          = amt;
            cnt_word[g][DT_LSB +: DT_W]     = dt;
            cnt_word[g][VC_LSB +: VC_W]     = vc;
        end
        assign amt_all[g*AMT_W +: AMT_W] = amt;
    end

    drop_status #(.NSRC(NSRC)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      ({drop_valid_i, fifo_ovf_i}),
        .clr_we_i   (reg_we_i && hit_status),
        .clr_bits_i (reg_wdata_i[STAT_LSB +: NSRC]),
        .en_we_i    (reg_we_i && hit_enable),
        .en_i       (reg_wdata_i[NSRC-1:0]),
        .stat_o     (stat_w),
        .en_o       (en_w),
        .irq_o      (irq_o)
    );

    // Read mux; unmapped addresses return zero.
    always_comb begin
        reg_rdata_o = '0;
        if (hit_status) reg_rdata_o[STAT_LSB +: NSRC] = stat_w;
        if (hit_enable) reg_rdata_o[NSRC-1:0] = en_w;
        for (int k = 0; k < NCAT; k++) begin
            if (reg_addr_i == ADDR_W'(cat_addr(k))) reg_rdata_o = cnt_word[k];
        end
    end
endmodule

// File: rtl/drop_tally_chk.sv
// Property checker for drop_tally_irq, attached by bind.
module drop_tally_chk
    import drop_tally_pkg::*;
#(
    parameter int AMT_W  = 24,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  fifo_ovf_i,
    input logic [NCAT-1:0]       drop_valid_i,
    input logic [NCAT*AMT_W-1:0] drop_amount_i,
    input logic                  reg_we_i,
    input logic [ADDR_W-1:0]     reg_addr_i,
    input logic [DATA_W-1:0]     reg_wdata_i,
    input logic                  irq_o,
    input logic [NSRC-1:0]       stat_q,
    input logic [NSRC-1:0]       en_q,
    input logic [NCAT*AMT_W-1:0] amt_all
);
    logic st_wr;
    logic en_wr;
    assign st_wr = reg_we_i && (reg_addr_i == ADDR_W'(ADDR_STATUS));
    assign en_wr = reg_we_i && (reg_addr_i == ADDR_W'(ADDR_ENABLE));

    // R3: FIFO overflow strobe is latched.
    a_r3_fifo_ovf_latched: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ovf_i |=> stat_q[0]);

    // R4: write-one clears status bit 20 when no new event.
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && reg_wdata_i[STAT_LSB] && !fifo_ovf_i) |=> !stat_q[0]);

    // R10: enabled FIFO overflow event raises the interrupt.
    a_r10_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ovf_i && en_q[0] && !en_wr) |=> irq_o);

    for (genvar k = 0; k < NCAT; k++) begin : g_k
        logic clr;
        assign clr = reg_we_i && (reg_addr_i == ADDR_W'(cat_addr(k)))
                     && (reg_wdata_i == '0);

        // R4: a drop wins over a same-cycle status clear.
        a_r4_drop_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
            drop_valid_i[k] |=> stat_q[k+1]);

        // R6: without a clear, the tally never goes down on an event.
        a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (drop_valid_i[k] && !clr) |=>
            (amt_all[k*AMT_W +: AMT_W] >= $past(amt_all[k*AMT_W +: AMT_W])));

        // R8: zero write clears the tally.
        a_r8_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !drop_valid_i[k]) |=> (amt_all[k*AMT_W +: AMT_W] == '0));

        // R9: collision loads exactly the new amount.
        a_r9_event_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && drop_valid_i[k]) |=>
            (amt_all[k*AMT_W +: AMT_W] == $past(drop_amount_i[k*AMT_W +: AMT_W])));
    end
endmodule

bind drop_tally_irq drop_tally_chk #(
    .AMT_W(AMT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_ovf_i    (fifo_ovf_i),
    .drop_valid_i  (drop_valid_i),
    .drop_amount_i (drop_amount_i),
    .reg_we_i      (reg_we_i),
    .reg_addr_i    (reg_addr_i),
    .reg_wdata_i   (reg_wdata_i),
    .irq_o         (irq_o),
    .stat_q        (stat_w),
    .en_q          (en_w),
    .amt_all       (amt_all)
);

// File: tb/drop_tally_irq_test.sv
module drop_tally_irq_test;
    localparam int CLK_PERIOD = 20;
    localparam logic [23:0] AMAX = 24'hFFFFFF;
    localparam logic [7:0] CADDR [4] = '{8'h08, 8'h14, 8'h10, 8'h0C};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_ovf_i = 1'b0;
    logic [3:0]  drop_valid_i = '0;
    logic [95:0] drop_amount_i = '0;
    logic [23:0] drop_dtype_i = '0;
    logic [7:0]  drop_vchan_i = '0;
    logic        reg_we_i = 1'b0;
    logic [7:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        irq_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    logic [23:0] m_amt [4];
    logic [5:0]  m_dt [4];
    logic [1:0]  m_vc [4];
    logic [4:0]  m_stat;
    logic [4:0]  m_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    drop_tally_irq uut (
        .clk(clk), .rst_n(rst_n), .fifo_ovf_i(fifo_ovf_i),
        .drop_valid_i(drop_valid_i), .drop_amount_i(drop_amount_i),
        .drop_dtype_i(drop_dtype_i), .drop_vchan_i(drop_vchan_i),
        .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input string tag, input logic [31:0] exp);
        reg_addr_i = a;
        #1;
        chk(tag, reg_rdata_o, exp);
    endtask

    // Read every mapped register and the interrupt; called in the low clock phase.
    task automatic check_all(input string tag);
        for (int k = 0; k < 4; k++) rd(CADDR[k], tag, {m_vc[k], m_dt[k], m_amt[k]});
        rd(8'h00, tag, {7'd0, m_stat, 20'd0});
        rd(8'h20, tag, {27'd0, m_en});
        chk(tag, {31'd0, irq_o}, {31'd0, |(m_stat & m_en)});
    endtask

    // One clock of stimulus with the bench model updated at the edge.
    task automatic step(input logic fov, input logic [3:0] dv, input logic [95:0] am,
                        input logic [23:0] dt, input logic [7:0] vc,
                        input logic we, input logic [7:0] a, input logic [31:0] wd);
        fifo_ovf_i = fov; drop_valid_i = dv; drop_amount_i = am;
        drop_dtype_i = dt; drop_vchan_i = vc;
        reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd;
        @(posedge clk);
        for (int k = 0; k < 4; k++) begin
            logic clr;
            logic [24:0] s;
            clr = we && (a == CADDR[k]) && (wd == 32'd0);
            if (dv[k]) begin
                s = (clr ? 25'd0 : {1'b0, m_amt[k]}) + {1'b0, am[k*24 +: 24]};
                m_amt[k] = s[24] ? AMAX : s[23:0];
                m_dt[k] = dt[k*6 +: 6];
                m_vc[k] = vc[k*2 +: 2];
            end else if (clr) begin
                m_amt[k] = '0; m_dt[k] = '0; m_vc[k] = '0;
            end
        end
        if (we && a == 8'h00) m_stat = m_stat & ~wd[24:20];
        m_stat = m_stat | {dv, fov};
        if (we && a == 8'h20) m_en = wd[4:0];
        @(negedge clk);
        fifo_ovf_i = 0; drop_valid_i = '0; reg_we_i = 0; reg_wdata_i = '0;
    endtask

    task automatic drop1(input int k, input logic [23:0] am, input logic [5:0] dt,
                         input logic [1:0] vc);
        logic [95:0] av = '0; logic [23:0] dv = '0; logic [7:0] vv = '0;
        av[k*24 +: 24] = am; dv[k*6 +: 6] = dt; vv[k*2 +: 2] = vc;
        step(0, 4'(1 << k), av, dv, vv, 0, 8'h00, 32'd0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] wd);
        step(0, 4'd0, '0, '0, '0, 1, a, wd);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin m_amt[k] = '0; m_dt[k] = '0; m_vc[k] = '0; end
        m_stat = '0; m_en = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R5 R7: every data type through every category
        for (int k = 0; k < 4; k++)
            for (int d = 0; d < 64; d++) begin
                drop1(k, 24'(d * 3 + k + 1), 6'(d), 2'(d + k));
                check_all("R2 R5 R7");
            end

        // R11: unmapped addresses and gaps
        rd(8'h04, "R11", 32'd0);
        rd(8'h18, "R11", 32'd0);
        rd(8'h24, "R11", 32'd0);
        rd(8'hFC, "R11", 32'd0);

        // R8: nonzero write ignored, zero write clears
        for (int k = 0; k < 4; k++) begin
            wr(CADDR[k], 32'h0000_0001);
            check_all("R8");
            wr(CADDR[k], 32'd0);
            check_all("R8");
        end

        // R6: saturation
        for (int k = 0; k < 4; k++) begin
            drop1(k, 24'hFFFFF0, 6'h2A, 2'd3);
            drop1(k, 24'h000020, 6'h15, 2'd1);
            check_all("R6");
            drop1(k, 24'h000001, 6'h01, 2'd2);
            check_all("R6");
            rd(CADDR[k], "R6", {2'd2, 6'h01, 24'hFFFFFF});
        end

        // R9: event coincides with a zero write
        for (int k = 0; k < 4; k++) begin
            logic [95:0] av = '0; logic [23:0] dv = '0; logic [7:0] vv = '0;
            av[k*24 +: 24] = 24'h000123 + 24'(k);
            dv[k*6 +: 6] = 6'h3C; vv[k*2 +: 2] = 2'd1;
            step(0, 4'(1 << k), av, dv, vv, 1, CADDR[k], 32'd0);
            check_all("R9");
            rd(CADDR[k], "R9", {2'd1, 6'h3C, 24'h000123 + 24'(k)});
        end

        // R3 R4: status sticky, partial W1C, set beats clear
        wr(8'h00, 32'h01F0_0000);
        check_all("R4");
        step(1, 4'b0000, '0, '0, '0, 0, 8'h00, 32'd0);
        step(0, 4'b1000, '0, '0, '0, 0, 8'h00, 32'd0);
        check_all("R3");
        wr(8'h00, 32'h0010_0000);
        check_all("R4");
        step(0, 4'b1000, '0, '0, '0, 1, 8'h00, 32'h0100_0000);
        check_all("R4");
        rd(8'h00, "R4", 32'h0100_0000);

        // R10: all status/enable combinations
        for (int s = 0; s < 32; s++)
            for (int m = 0; m < 32; m++) begin
                step(s[0], 4'(s >> 1), '0, '0, '0, 1, 8'h00, 32'h01F0_0000);
                wr(8'h20, 32'(m) | 32'hFFFF_FFE0);
                rd(8'h20, "R10", 32'(m));
                rd(8'h00, "R3 R10", {7'd0, 5'(s), 20'd0});
                chk("R10", {31'd0, irq_o}, {31'd0, |(5'(s) & 5'(m))});
            end
        check_all("R10");

        done = 1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL R1: watchdog expired, got running expected finished");
            report();
        end
    end
endmodule